// File: doc/BRIEF.md
# Bidirectional Open-Drain Two-Wire Channel Selector

This block joins one upstream two-wire open-drain pair (a data line and a clock line) to one of four downstream pairs. Each pad is modelled as open-drain. The block reads every pad's level through a two-stage synchronizer and produces one output-enable for each pad. A high enable pulls that pad to ground. A low enable releases the pad, and an external pull-up then takes it high. A 2-bit select input picks which downstream pair is connected.

Each of the two lines is a wired-AND repeater that works in both directions. The first side seen low on the connected path becomes the source, and the block pulls the matching pad on the other side low. When the source lets go, the drive stays on for a set number of hold cycles. For a short guard window after that, low levels read back from the driven side are not treated as a new source, so the block's own echo cannot lock the bus low. A new select value takes effect only when the whole bus is quiet. Two or more controllers can therefore share the upstream side, and a downstream device can stretch the clock.

Top module: `bus_sel_mux`

## Requirements
- R1: While `rst` is high, every output-enable is low on the next clock edge and the active channel is 0.
- R2: When the upstream pad of a line is held low, the enable of that line's pad on the active channel goes high on the third rising edge after the pad falls (two synchronizer stages plus one state register). The enables of all other downstream pads of that line stay low.
- R3: When the active channel's downstream pad of a line is held low, the upstream enable of that line goes high on the third rising edge after the pad falls. A low on a downstream pad of a channel that is not active has no effect on any enable.
- R4: After the source pad returns high, the driven enable stays high for exactly HOLD_CYC further cycles, counted from the first cycle in which the synchronized source reads high. With HOLD_CYC=4 it falls on the sixth rising edge after the pad rises.
- R5: On one line, the upstream enable and any downstream enable are never high at the same time. A low read back from the driven side, while the block is driving it and for SYNC_STAGES+1 cycles after the drive is released, never starts drive in the opposite direction, so the lines return to released after a transfer.
- R6: The select value is decoded as 00 to channel 0, 01 to channel 1, 10 to channel 2 and 11 to channel 3.
- R7: A new select value is taken only in a cycle in which both lines have no source and every synchronized pad reads high. A change requested during a transfer stays pending until the bus is idle.
- R8: The clock line behaves the same way as the data line and is fully independent of it. In both directions, activity on one line never asserts an enable on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_in | input | SEL_W (2) | Requested downstream channel |
| up_sda_in | input | 1 | Upstream data pad level |
| up_scl_in | input | 1 | Upstream clock pad level |
| up_sda_oe | output | 1 | Pull upstream data pad low |
| up_scl_oe | output | 1 | Pull upstream clock pad low |
| dn_sda_in | input | NUM_CH (4) | Downstream data pad levels, one bit per channel |
| dn_scl_in | input | NUM_CH (4) | Downstream clock pad levels, one bit per channel |
| dn_sda_oe | output | NUM_CH (4) | Pull downstream data pads low, one bit per channel |
| dn_scl_oe | output | NUM_CH (4) | Pull downstream clock pads low, one bit per channel |

## Verification
Some properties are checked on every cycle. Enables are cleared by reset. Pads outside the active channel are never enabled. No line drives in both directions at once. A new drive starts only after the opposite direction has been quiet for a cycle. The active channel never changes while the bus is busy. Other behaviour needs the bench's scenarios with modelled open-drain pads and pull-ups. These cover the exact three-cycle propagation latency, the exact hold length after release, freedom from lockup after the echo settles, and a deferred select change that takes effect once the bus goes idle.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    // Which side of a line currently owns the low level.
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,  // no source, both sides released
        DIR_DOWN = 2'd1,  // upstream is source, block drives downstream
        DIR_UP   = 2'd2   // downstream is source, block drives upstream
    } dir_e;

    localparam int N_LINES  = 2;
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;

    // Cycles a line stays owned after its source releases: hold plus echo guard.
    function automatic int owned_tail(input int hold, input int stages);
        return hold + stages + 1;
    endfunction

endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/chsel_sel_ctrl.sv
module chsel_sel_ctrl #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_req,
    input  logic             bus_idle,
    output logic [SEL_W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (bus_idle) begin
            active <= sel_req;
        end
    end
endmodule

// File: rtl/chsel_line_rep.sv
module chsel_line_rep
    import chsel_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SEL_W       = 2,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  active,
    input  logic              up_in,
    input  logic [NUM_CH-1:0] dn_in,
    output logic              up_oe,
    output logic [NUM_CH-1:0] dn_oe,
    output logic              idle
);
    localparam int TAIL  = owned_tail(HOLD_CYC, SYNC_STAGES);
    localparam int CNT_W = $clog2(TAIL + 1);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(TAIL - 1);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CYC);

    dir_e             dir;
    logic [CNT_W-1:0] cnt;
    logic             dn_act;
    logic             src_lvl;
    logic             driving;

    assign dn_act  = dn_in[active];
    // Level of the side that started the low; the driven side is ignored.
    assign src_lvl = (dir == DIR_DOWN) ? up_in : dn_act;
    assign driving = (dir != DIR_NONE) && (cnt < HOLD_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= DIR_NONE;
            cnt <= '0;
        end else if (dir == DIR_NONE) begin
            cnt <= '0;
            if (!up_in) begin
                dir <= DIR_DOWN;
            end else if (!dn_act) begin
                dir <= DIR_UP;
            end
        end else if (!src_lvl) begin
            cnt <= '0;                  // source still (or again) low
        end else if (cnt == LAST) begin
            dir <= DIR_NONE;            // hold and echo guard both expired
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign up_oe = driving && (dir == DIR_UP);
    assign dn_oe = (driving && (dir == DIR_DOWN)) ? (NUM_CH'(1) << active) : '0;
    assign idle  = (dir == DIR_NONE);
endmodule

// File: rtl/bus_sel_mux.sv
module bus_sel_mux
    import chsel_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SEL_W       = $clog2(NUM_CH),
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              up_sda_in,
    input  logic              up_scl_in,
    output logic              up_sda_oe,
    output logic              up_scl_oe,
    input  logic [NUM_CH-1:0] dn_sda_in,
    input  logic [NUM_CH-1:0] dn_scl_in,
    output logic [NUM_CH-1:0] dn_sda_oe,
    output logic [NUM_CH-1:0] dn_scl_oe
);
    localparam int PADS = N_LINES * (NUM_CH + 1);

    logic [PADS-1:0]                 pads_s;
    logic [N_LINES-1:0]              up_s;
    logic [N_LINES-1:0][NUM_CH-1:0]  dn_s;
    logic [N_LINES-1:0]              up_oe_w;
    logic [N_LINES-1:0][NUM_CH-1:0]  dn_oe_w;
    logic [N_LINES-1:0]              line_idle;
    logic [SEL_W-1:0]                active_ch;
    logic                            bus_idle;

    chsel_sync #(.W(PADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dn_scl_in, dn_sda_in, up_scl_in, up_sda_in}),
        .q   (pads_s)
    );

    assign up_s[LINE_SDA] = pads_s[0];
    assign up_s[LINE_SCL] = pads_s[1];
    assign dn_s[LINE_SDA] = pads_s[2 +: NUM_CH];
    assign dn_s[LINE_SCL] = pads_s[2 + NUM_CH +: NUM_CH];

    assign bus_idle = (&line_idle) && (&pads_s);

    chsel_sel_ctrl #(.SEL_W(SEL_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_req  (sel_in),
        .bus_idle (bus_idle),
        .active   (active_ch)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        chsel_line_rep #(
            .NUM_CH      (NUM_CH),
            .SEL_W       (SEL_W),
            .HOLD_CYC    (HOLD_CYC),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_rep (
            .clk    (clk),
            .rst    (rst),
            .active (active_ch),
            .up_in  (up_s[l]),
            .dn_in  (dn_s[l]),
            .up_oe  (up_oe_w[l]),
            .dn_oe  (dn_oe_w[l]),
            .idle   (line_idle[l])
        );
    end

    assign up_sda_oe = up_oe_w[LINE_SDA];
    assign up_scl_oe = up_oe_w[LINE_SCL];
    assign dn_sda_oe = dn_oe_w[LINE_SDA];
    assign dn_scl_oe = dn_oe_w[LINE_SCL];
endmodule

// File: rtl/bus_sel_mux_chk.sv
module bus_sel_mux_chk #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  active,
    input logic              bus_idle,
    input logic              up_sda_oe,
    input logic              up_scl_oe,
    input logic [NUM_CH-1:0] dn_sda_oe,
    input logic [NUM_CH-1:0] dn_scl_oe
);
    logic [NUM_CH-1:0] act_mask;
    assign act_mask = NUM_CH'(1) << active;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!up_sda_oe && !up_scl_oe && dn_sda_oe == '0 && dn_scl_oe == '0 && active == '0));

    p_unsel_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ((dn_sda_oe & ~act_mask) == '0) && ((dn_scl_oe & ~act_mask) == '0));

    p_one_dir_sda_r5: assert property (@(posedge clk) disable iff (rst)
        !(up_sda_oe && (|dn_sda_oe)));

    p_one_dir_scl_r5: assert property (@(posedge clk) disable iff (rst)
        !(up_scl_oe && (|dn_scl_oe)));

    p_no_echo_up_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(up_sda_oe) |-> ($past(dn_sda_oe) == '0));

    p_no_echo_dn_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(|dn_sda_oe) |-> !$past(up_sda_oe));

    p_onehot_dn_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_sda_oe) && $onehot0(dn_scl_oe));

    p_sel_deferred_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_idle |=> $stable(active));
endmodule

bind bus_sel_mux bus_sel_mux_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .active    (active_ch),
    .bus_idle  (bus_idle),
    .up_sda_oe (up_sda_oe),
    .up_scl_oe (up_scl_oe),
    .dn_sda_oe (dn_sda_oe),
    .dn_scl_oe (dn_scl_oe)
);

// File: tb/test_bus_sel_mux.sv
`timescale 1ns/1ps
module test_bus_sel_mux;
    localparam int NUM_CH = 4;
    localparam int HOLD   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sel = 2'b00;
    // ext = 1 means an outside device pulls that pad low
    logic up_sda_ext = 1'b0, up_scl_ext = 1'b0;
    logic [NUM_CH-1:0] dn_sda_ext = '0, dn_scl_ext = '0;

    logic up_sda_oe, up_scl_oe;
    logic [NUM_CH-1:0] dn_sda_oe, dn_scl_oe;
    logic up_sda_pad, up_scl_pad;
    logic [NUM_CH-1:0] dn_sda_pad, dn_scl_pad;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // open-drain pads with pull-ups
    assign up_sda_pad = ~(up_sda_oe | up_sda_ext);
    assign up_scl_pad = ~(up_scl_oe | up_scl_ext);
    assign dn_sda_pad = ~(dn_sda_oe | dn_sda_ext);
    assign dn_scl_pad = ~(dn_scl_oe | dn_scl_ext);

    bus_sel_mux #(.NUM_CH(NUM_CH), .HOLD_CYC(HOLD)) i_bus_sel_mux (
        .clk       (clk),
        .rst       (rst),
        .sel_in    (sel),
        .up_sda_in (up_sda_pad),
        .up_scl_in (up_scl_pad),
        .up_sda_oe (up_sda_oe),
        .up_scl_oe (up_scl_oe),
        .dn_sda_in (dn_sda_pad),
        .dn_scl_in (dn_scl_pad),
        .dn_sda_oe (dn_sda_oe),
        .dn_scl_oe (dn_scl_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int all_oe();
        return {up_scl_oe, up_sda_oe, dn_scl_oe, dn_sda_oe};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        cyc(3);
        chk("R1 enables after reset", all_oe(), 0);
        rst = 1'b0;
        cyc(2);
        chk("R1 enables idle", all_oe(), 0);
    endtask

    // upstream data low routed to channel ch; also checks exact latency
    task automatic t_down_path(input int ch);
        sel = 2'(ch);
        cyc(2);
        up_sda_ext = 1'b1;
        cyc(2);
        chk("R2 no drive before latency", int'(dn_sda_oe), 0);
        cyc(1);
        chk("R6 R2 selected channel driven", int'(dn_sda_oe), 1 << ch);
        chk("R8 clock line untouched", int'({up_scl_oe, dn_scl_oe}), 0);
        up_sda_ext = 1'b0;
        cyc(12);
        chk("R5 released after transfer", all_oe(), 0);
    endtask

    task automatic t_up_path();
        sel = 2'd1;
        cyc(2);
        dn_sda_ext[1] = 1'b1;
        cyc(2);
        chk("R3 no drive before latency", int'(up_sda_oe), 0);
        cyc(1);
        chk("R3 upstream driven", int'(up_sda_oe), 1);
        dn_sda_ext[1] = 1'b0;
        cyc(12);
        chk("R3 released", all_oe(), 0);
    endtask

    task automatic t_unselected();
        bit bad = 0;
        sel = 2'd0;
        cyc(2);
        dn_sda_ext[2] = 1'b1;
        dn_scl_ext[3] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (all_oe() != 0) bad = 1;
        end
        chk("R3 unselected low ignored", int'(bad), 0);
        dn_sda_ext = '0;
        dn_scl_ext = '0;
        cyc(4);
    endtask

    task automatic t_hold();
        sel = 2'd3;
        cyc(2);
        up_sda_ext = 1'b1;
        cyc(6);
        up_sda_ext = 1'b0;
        cyc(HOLD + 1);
        chk("R4 still held", int'(dn_sda_oe), 4'b1000);
        cyc(1);
        chk("R4 released after hold", int'(dn_sda_oe), 0);
        cyc(10);
    endtask

    task automatic t_echo();
        bit bad = 0;
        sel = 2'd0;
        cyc(2);
        up_sda_ext = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (up_sda_oe) bad = 1;
        end
        up_sda_ext = 1'b0;
        for (int i = 0; i < 25; i++) begin
            cyc(1);
            if (up_sda_oe) bad = 1;
        end
        chk("R5 echo never reversed", int'(bad), 0);
        chk("R5 bus not locked", all_oe(), 0);
    endtask

    task automatic t_defer();
        sel = 2'd0;
        cyc(2);
        up_sda_ext = 1'b1;
        cyc(4);
        sel = 2'd2;
        cyc(4);
        chk("R7 old channel kept mid-transfer", int'(dn_sda_oe), 4'b0001);
        up_sda_ext = 1'b0;
        cyc(12);
        up_sda_ext = 1'b1;
        cyc(3);
        chk("R7 new channel after idle", int'(dn_sda_oe), 4'b0100);
        up_sda_ext = 1'b0;
        cyc(12);
    endtask

    task automatic t_scl();
        sel = 2'd2;
        cyc(2);
        up_scl_ext = 1'b1;
        cyc(3);
        chk("R8 clock downstream", int'(dn_scl_oe), 4'b0100);
        chk("R8 data line quiet", int'({up_sda_oe, dn_sda_oe}), 0);
        up_scl_ext = 1'b0;
        cyc(12);
        dn_scl_ext[2] = 1'b1;  // downstream stretches the clock
        cyc(3);
        chk("R8 clock upstream", int'(up_scl_oe), 1);
        dn_scl_ext[2] = 1'b0;
        cyc(12);
        chk("R8 clock released", all_oe(), 0);
    endtask

    initial begin
        t_reset();
        for (int ch = 0; ch < NUM_CH; ch++) t_down_path(ch);
        t_up_path();
        t_unselected();
        t_hold();
        t_echo();
        t_defer();
        t_scl();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule